// File: doc/BRIEF.md
# Auto-Increment Address Generation Unit

This unit forms the memory address of a load or store from a base register value and a signed 16-bit offset. It can also write the updated base back to the register file. One adder produces the effective-address sum. A multiplexer then picks the address that goes to memory: the sum itself, or the untouched base value. This gives pre-increment or post-increment addressing. In every update mode the sum is also the new base value, so no second adder is needed.

The new base is not written at once. Each update waits in a small queue until later pipeline stages report that its instruction can no longer trap.

- An instruction that commits has its update sent out on a dedicated base-writeback port.
- A trap throws away every unresolved update, so the faulting instruction can be restarted with nothing to undo.
- The writeback port may be busy for any number of cycles. A committed update simply waits at the head of the queue until the port grants it.

While updates are pending, a read of a register can ask the unit whether that register has an update in flight. The unit answers with a hazard flag and the youngest pending value, so the reader can either use that value or stall.

Top module: `agu_autoinc`

## Requirements
- R1: For mode 2'b01 (pre-increment), `mem_addr` equals `req_base` plus the offset sign-extended from 16 to 32 bits, in the same cycle as the request.
- R2: For mode 2'b10 (post-increment), `mem_addr` equals `req_base` unchanged, in the same cycle as the request.
- R3: Modes 2'b00 and 2'b11 address memory at the sign-extended sum and never create a pending update: no writeback and no hazard ever results from them.
- R4: An accepted pre- or post-increment request produces exactly one writeback whose `wb_data` is base plus sign-extended offset and whose `wb_reg` is `req_reg`.
- R5: `wb_valid` is never raised for an update until a resolution with `res_fault`=0 has been applied to it; `wb_valid` rises on the edge after that resolution.
- R6: A resolution with `res_fault`=1 discards every pending update not yet committed; none of them is ever written back, and they stop raising hazards from the next cycle on.
- R7: While `wb_grant` is low, a committed head update keeps `wb_valid` high with stable `wb_reg` and `wb_data`, for any number of cycles; it leaves the queue at the first edge with `wb_grant` high.
- R8: The queue holds at most 2 updates. With 2 pending, `req_ready` is low and a request gives `mem_valid`=0 and is not queued.
- R9: With `rd_en` high, `rd_hazard` is high exactly when a pending update targets `rd_reg`, and `rd_fwd` then carries the value of the youngest such update.
- R10: After reset `req_ready` is high, `wb_valid` is low and `rd_hazard` is low.
- R11: Updates are written back in the order their requests were accepted.
- R12: Each resolution applies to the oldest update not yet resolved, so with two pending, a commit followed by a fault writes the first and discards the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Address request present |
| req_mode | input | 2 | 00 plain, 01 pre-increment, 10 post-increment, 11 plain |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed offset |
| req_reg | input | 5 | Base register index |
| req_ready | output | 1 | Unit can take a request |
| mem_valid | output | 1 | Request accepted, `mem_addr` valid |
| mem_addr | output | 32 | Memory address |
| res_valid | input | 1 | Resolution for the oldest unresolved update |
| res_fault | input | 1 | 1: instruction trapped, 0: instruction committed |
| wb_grant | input | 1 | Base writeback port free this cycle |
| wb_valid | output | 1 | Committed update waiting for the port |
| wb_reg | output | 5 | Register index of the update |
| wb_data | output | 32 | New base value |
| rd_en | input | 1 | Hazard lookup enable |
| rd_reg | input | 5 | Register index being read |
| rd_hazard | output | 1 | Pending update targets `rd_reg` |
| rd_fwd | output | 32 | Youngest pending value for `rd_reg` |

## Verification
`mem_valid` and `mem_addr` are combinational: the bench drives a request on a falling edge and checks them 5 ns later in that same cycle. A pending update becomes visible to the hazard lookup one rising edge after its request is accepted. `wb_valid` rises one rising edge after a committing resolution, and the update leaves the queue at the first rising edge where `wb_grant` is high. A monitor samples the writeback port 2 ns before each rising edge and compares every granted writeback, in order, against a queue of expected updates. Entries are added to that queue when requests are accepted and dropped when the bench sends a fault.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_PRE   = 2'b01,
    MODE_POST  = 2'b10,
    MODE_RSVD  = 2'b11
  } agu_mode_e;

  // Only the two increment modes carry a base update.
  function automatic logic mode_updates(input logic [1:0] m);
    return (m == MODE_PRE) || (m == MODE_POST);
  endfunction

endpackage

// File: rtl/agu_ea_path.sv
module agu_ea_path
  import agu_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] offset_i,
  input  logic [1:0]    mode_i,
  output logic [AW-1:0] ea_sum_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          updates_o
);

  logic [AW-1:0] off_ext;

  generate
    if (AW > OW) begin : g_sext
      localparam int EXT_W = AW - OW;
      assign off_ext = {{EXT_W{offset_i[OW-1]}}, offset_i};
    end else begin : g_trunc
      assign off_ext = offset_i[AW-1:0];
    end
  endgenerate

  // The single adder: its sum is both the address and the new base.
  assign ea_sum_o = base_i + off_ext;

  always_comb begin
    if (mode_i == MODE_POST) mem_addr_o = base_i;
    else                     mem_addr_o = ea_sum_o;
  end

  assign updates_o = mode_updates(mode_i);

endmodule

// File: rtl/agu_upd_queue.sv
module agu_upd_queue #(
  parameter int DEPTH = 2,
  parameter int AW    = 32,
  parameter int RW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [RW-1:0] push_idx_i,
  input  logic [AW-1:0] push_val_i,
  input  logic          res_valid_i,
  input  logic          res_fault_i,
  input  logic          wb_grant_i,
  output logic          full_o,
  output logic          wb_valid_o,
  output logic [RW-1:0] wb_idx_o,
  output logic [AW-1:0] wb_val_o,
  output logic          ord_vld_o [DEPTH],
  output logic [RW-1:0] ord_idx_o [DEPTH],
  output logic [AW-1:0] ord_val_o [DEPTH]
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  function automatic logic [PTR_W-1:0] slot_of(input logic [PTR_W-1:0] h, input int k);
    int s;
    s = (int'(h) + k) % DEPTH;
    return PTR_W'(s);
  endfunction

  logic [AW-1:0]    val_q [DEPTH];
  logic [RW-1:0]    idx_q [DEPTH];
  logic [DEPTH-1:0] cmt_q, cmt_d;
  logic [PTR_W-1:0] head_q, head_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic [CNT_W-1:0] ncmt_c, keep_c;
  logic             run_c, pop_c, commit_c, fault_c;
  logic [PTR_W-1:0] push_slot_c, commit_slot_c;

  // Next-state logic
  always_comb begin
    // Committed entries form a prefix of the queue, oldest first.
    ncmt_c = '0;
    run_c  = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      if (run_c && (k < int'(cnt_q)) && cmt_q[slot_of(head_q, k)])
        ncmt_c = ncmt_c + CNT_W'(1);
      else
        run_c = 1'b0;
    end

    fault_c       = res_valid_i && res_fault_i;
    commit_c      = res_valid_i && !res_fault_i && (ncmt_c < cnt_q);
    pop_c         = (cnt_q != '0) && cmt_q[head_q] && wb_grant_i;
    keep_c        = fault_c ? ncmt_c : cnt_q;
    push_slot_c   = slot_of(head_q, int'(keep_c));
    commit_slot_c = slot_of(head_q, int'(ncmt_c));

    cmt_d = cmt_q;
    if (push_i)   cmt_d[push_slot_c]   = 1'b0;
    if (commit_c) cmt_d[commit_slot_c] = 1'b1;

    cnt_d  = keep_c + CNT_W'(push_i) - CNT_W'(pop_c);
    head_d = pop_c ? slot_of(head_q, 1) : head_q;
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
      cmt_q  <= '0;
    end else begin
      head_q <= head_d;
      cnt_q  <= cnt_d;
      cmt_q  <= cmt_d;
    end
  end

  // Payload registers: loaded only on push, never reset
  always_ff @(posedge clk) begin
    if (push_i) begin
      val_q[push_slot_c] <= push_val_i;
      idx_q[push_slot_c] <= push_idx_i;
    end
  end

  assign full_o     = (cnt_q == CNT_W'(DEPTH));
  assign wb_valid_o = (cnt_q != '0) && cmt_q[head_q];
  assign wb_idx_o   = idx_q[head_q];
  assign wb_val_o   = val_q[head_q];

  // Entries in age order for the hazard lookup
  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      ord_vld_o[k] = (k < int'(cnt_q));
      ord_idx_o[k] = idx_q[slot_of(head_q, k)];
      ord_val_o[k] = val_q[slot_of(head_q, k)];
    end
  end

  // R8: nothing may be pushed into a full queue
  p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !push_i);

  // R8: occupancy never exceeds the capacity
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R7: a waiting writeback holds steady until granted
  p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid_o && !wb_grant_i) |=> (wb_valid_o && $stable(wb_val_o) && $stable(wb_idx_o)));

  // R6: after a fault with no push, only committed entries remain
  p_fault_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_i && res_fault_i && !push_i) |=> (ncmt_c == cnt_q));

endmodule

// File: rtl/agu_hazard.sv
module agu_hazard #(
  parameter int DEPTH = 2,
  parameter int AW    = 32,
  parameter int RW    = 5
) (
  input  logic          rd_en_i,
  input  logic [RW-1:0] rd_idx_i,
  input  logic          ord_vld_i [DEPTH],
  input  logic [RW-1:0] ord_idx_i [DEPTH],
  input  logic [AW-1:0] ord_val_i [DEPTH],
  output logic          hazard_o,
  output logic [AW-1:0] fwd_o
);

  logic hit_c;

  // Scan oldest to youngest; the last match is the youngest.
  always_comb begin
    hit_c = 1'b0;
    fwd_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (ord_vld_i[k] && (ord_idx_i[k] == rd_idx_i)) begin
        hit_c = 1'b1;
        fwd_o = ord_val_i[k];
      end
    end
    hazard_o = rd_en_i && hit_c;
  end

endmodule

// File: rtl/agu_autoinc.sv
module agu_autoinc #(
  parameter int AW    = 32,
  parameter int OW    = 16,
  parameter int RW    = 5,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_mode,
  input  logic [AW-1:0] req_base,
  input  logic [OW-1:0] req_offset,
  input  logic [RW-1:0] req_reg,
  output logic          req_ready,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  input  logic          res_valid,
  input  logic          res_fault,
  input  logic          wb_grant,
  output logic          wb_valid,
  output logic [RW-1:0] wb_reg,
  output logic [AW-1:0] wb_data,
  input  logic          rd_en,
  input  logic [RW-1:0] rd_reg,
  output logic          rd_hazard,
  output logic [AW-1:0] rd_fwd
);

  // Reset asserts asynchronously and is released on the clock.
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic [AW-1:0] ea_sum;
  logic          wants_upd, full, push;
  logic          ord_vld [DEPTH];
  logic [RW-1:0] ord_idx [DEPTH];
  logic [AW-1:0] ord_val [DEPTH];

  agu_ea_path #(.AW(AW), .OW(OW)) u_ea (
    .base_i     (req_base),
    .offset_i   (req_offset),
    .mode_i     (req_mode),
    .ea_sum_o   (ea_sum),
    .mem_addr_o (mem_addr),
    .updates_o  (wants_upd)
  );

  assign req_ready = !full;
  assign mem_valid = req_valid && req_ready;
  assign push      = mem_valid && wants_upd;

  agu_upd_queue #(.DEPTH(DEPTH), .AW(AW), .RW(RW)) u_q (
    .clk         (clk),
    .rst_n       (rst_s2),
    .push_i      (push),
    .push_idx_i  (req_reg),
    .push_val_i  (ea_sum),
    .res_valid_i (res_valid),
    .res_fault_i (res_fault),
    .wb_grant_i  (wb_grant),
    .full_o      (full),
    .wb_valid_o  (wb_valid),
    .wb_idx_o    (wb_reg),
    .wb_val_o    (wb_data),
    .ord_vld_o   (ord_vld),
    .ord_idx_o   (ord_idx),
    .ord_val_o   (ord_val)
  );

  agu_hazard #(.DEPTH(DEPTH), .AW(AW), .RW(RW)) u_hz (
    .rd_en_i   (rd_en),
    .rd_idx_i  (rd_reg),
    .ord_vld_i (ord_vld),
    .ord_idx_i (ord_idx),
    .ord_val_i (ord_val),
    .hazard_o  (rd_hazard),
    .fwd_o     (rd_fwd)
  );

  // R5: a writeback appears only right after a committing resolution
  p_wb_after_commit_r5: assert property (@(posedge clk) disable iff (!rst_s2)
    $rose(wb_valid) |-> $past(res_valid && !res_fault));

endmodule

// File: tb/test_agu_autoinc.sv
module test_agu_autoinc;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_mode;
  logic [31:0] req_base;
  logic [15:0] req_offset;
  logic [4:0]  req_reg;
  logic        req_ready, mem_valid;
  logic [31:0] mem_addr;
  logic        res_valid, res_fault, wb_grant;
  logic        wb_valid;
  logic [4:0]  wb_reg;
  logic [31:0] wb_data;
  logic        rd_en;
  logic [4:0]  rd_reg;
  logic        rd_hazard;
  logic [31:0] rd_fwd;

  always #10 clk = ~clk;

  agu_autoinc i_agu_autoinc (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_mode(req_mode), .req_base(req_base),
    .req_offset(req_offset), .req_reg(req_reg), .req_ready(req_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr),
    .res_valid(res_valid), .res_fault(res_fault), .wb_grant(wb_grant),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
    .rd_en(rd_en), .rd_reg(rd_reg), .rd_hazard(rd_hazard), .rd_fwd(rd_fwd)
  );

  typedef struct { logic [4:0] r; logic [31:0] v; } wb_t;
  wb_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] o);
    return {{16{o[15]}}, o};
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic do_req(input logic [1:0] m, input logic [31:0] b, input logic [15:0] o,
                        input logic [4:0] r, input logic [31:0] exp_addr,
                        input bit exp_acc, input string tag);
    wb_t e;
    req_valid = 1'b1; req_mode = m; req_base = b; req_offset = o; req_reg = r;
    #5;
    chk({tag, " mem_valid"}, {31'd0, mem_valid}, {31'd0, exp_acc});
    if (exp_acc) chk({tag, " mem_addr"}, mem_addr, exp_addr);
    if (exp_acc && (m == 2'b01 || m == 2'b10)) begin
      e.r = r; e.v = b + sx(o);
      exp_q.push_back(e);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic resolve(input bit fault);
    res_valid = 1'b1; res_fault = fault;
    @(negedge clk);
    res_valid = 1'b0; res_fault = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hz(input logic [4:0] r, input bit exp_h, input logic [31:0] exp_v,
                    input string tag);
    rd_en = 1'b1; rd_reg = r;
    #5;
    chk({tag, " rd_hazard"}, {31'd0, rd_hazard}, {31'd0, exp_h});
    if (exp_h) chk({tag, " rd_fwd"}, rd_fwd, exp_v);
  endtask

  // Scoreboard monitor: compares granted writebacks in order (R4, R11).
  always @(negedge clk) begin
    #8;
    if (rst_n && wb_valid && wb_grant) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R6 unexpected writeback: actual reg %0d data %h expected none",
                 wb_reg, wb_data);
      end else begin
        wb_t e;
        e = exp_q.pop_front();
        chk("R4/R11 wb_reg", {27'd0, wb_reg}, {27'd0, e.r});
        chk("R4/R11 wb_data", wb_data, e.v);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'b00; req_base = '0;
    req_offset = '0; req_reg = '0; res_valid = 1'b0; res_fault = 1'b0;
    wb_grant = 1'b1; rd_en = 1'b0; rd_reg = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R10: state after reset
    chk("R10 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R10 wb_valid", {31'd0, wb_valid}, 32'd0);
    hz(5'd3, 1'b0, 32'd0, "R10");
    @(negedge clk);

    // R1: pre-increment addresses at the sum; R5/R9 before commit
    do_req(2'b01, 32'h0000_1000, 16'h0010, 5'd3, 32'h0000_1010, 1'b1, "R1 pre");
    chk("R5 no wb before commit", {31'd0, wb_valid}, 32'd0);
    hz(5'd3, 1'b1, 32'h0000_1010, "R9 pending");
    @(negedge clk);
    chk("R5 still no wb", {31'd0, wb_valid}, 32'd0);
    resolve(1'b0);
    #5 chk("R5 wb after commit", {31'd0, wb_valid}, 32'd1);
    idle(2);

    // R2: post-increment with a negative offset
    do_req(2'b10, 32'h0000_2000, 16'hFFF0, 5'd5, 32'h0000_2000, 1'b1, "R2 post");
    resolve(1'b0);
    idle(2);

    // R3: plain and reserved modes never update
    do_req(2'b00, 32'h0000_0100, 16'h8001, 5'd13, 32'hFFFF_8101, 1'b1, "R3 plain");
    do_req(2'b11, 32'h0000_0100, 16'h0001, 5'd13, 32'h0000_0101, 1'b1, "R3 reserved");
    idle(2);
    hz(5'd13, 1'b0, 32'd0, "R3");
    chk("R3 wb_valid", {31'd0, wb_valid}, 32'd0);
    chk("R3 req_ready", {31'd0, req_ready}, 32'd1);
    @(negedge clk);

    // R8/R9/R7/R11: fill the queue with the port held busy
    wb_grant = 1'b0;
    do_req(2'b01, 32'h0000_3000, 16'h0004, 5'd7, 32'h0000_3004, 1'b1, "R1 fill a");
    do_req(2'b10, 32'h0000_3004, 16'h0004, 5'd7, 32'h0000_3004, 1'b1, "R2 fill b");
    #5 chk("R8 ready low when full", {31'd0, req_ready}, 32'd0);
    do_req(2'b01, 32'h0000_9000, 16'h0001, 5'd12, 32'h0, 1'b0, "R8 refused");
    hz(5'd7, 1'b1, 32'h0000_3008, "R9 youngest");
    hz(5'd12, 1'b0, 32'd0, "R8 refused not queued");
    @(negedge clk);
    resolve(1'b0);
    resolve(1'b0);
    idle(3);
    #5;
    chk("R7 held valid", {31'd0, wb_valid}, 32'd1);
    chk("R7 held data", wb_data, 32'h0000_3004);
    idle(4);
    #5;
    chk("R7 still held", wb_data, 32'h0000_3004);
    @(negedge clk);
    wb_grant = 1'b1;
    idle(4);
    chk("R11 all drained", exp_q.size(), 32'd0);

    // R6: a fault discards the pending update
    do_req(2'b01, 32'h0000_4000, 16'h0020, 5'd9, 32'h0000_4020, 1'b1, "R1 to fault");
    void'(exp_q.pop_back());
    resolve(1'b1);
    idle(3);
    chk("R6 no wb after fault", {31'd0, wb_valid}, 32'd0);
    hz(5'd9, 1'b0, 32'd0, "R6");
    @(negedge clk);

    // R12: commit then fault hits the oldest, then the next
    do_req(2'b01, 32'h0000_5000, 16'h0008, 5'd10, 32'h0000_5008, 1'b1, "R12 first");
    do_req(2'b10, 32'h0000_6000, 16'hFFFC, 5'd11, 32'h0000_6000, 1'b1, "R12 second");
    resolve(1'b0);
    void'(exp_q.pop_back());
    resolve(1'b1);
    idle(4);
    chk("R12 scoreboard empty", exp_q.size(), 32'd0);
    chk("R12 no wb left", {31'd0, wb_valid}, 32'd0);
    hz(5'd11, 1'b0, 32'd0, "R12");
    @(negedge clk);

    summary();
  end

endmodule